// File: doc/BRIEF.md
# Interrupt-Driven Word Input Port

This block is an I/O port that sits between a processor bus and one simple peripheral. The processor addresses it with single-cycle command strobes. A read command makes the port fetch one 16-bit word from the peripheral on its own. While that fetch is under way, the processor is free to do other work. When the word has landed in the port's holding register, the port raises an interrupt request and keeps the word. The word stays there until the processor issues a data-take command. On that command the port drives the word back on its read-data lines and becomes ready for the next operation.

The same port can also do the following:
- forward a word from the processor to the peripheral (write);
- report a status word (test);
- be switched on and off, and have its error flag cleared (control).

Commands sent to any other bus address are ignored. Both peripheral-side transfers use valid/ready handshakes:
- A word moves on a rising clock edge where valid and ready are both high.
- The inbound side raises ready only while a fetch is pending.
- The outbound side holds valid and data steady until ready is seen. The peripheral may therefore stall it for any number of cycles.

Top module: `irq_input_port`

## Requirements
- R1: After reset, irq, dev_in_ready, dev_out_valid and bus_rvalid are low, and the status word reads zero.
- R2: A strobe on bus_req acts only when bus_addr equals the parameter BASE_ADDR. Strobes to other addresses, and command codes 5 to 7, change no state and produce no response.
- R3: Control (code 0) sets the enable flag from bus_wdata[0]. If bus_wdata[1] is 1, it also clears the error flag.
- R4: Test (code 1) drives bus_rvalid high in the next cycle, with bus_rdata carrying the status word: bit 0 busy, bit 1 data held, bit 2 error, bit 3 enabled, bit 4 write pending, all other bits zero.
- R5: Read (code 2) issued while enabled and idle sets busy from the next cycle. dev_in_ready then stays high until one word is accepted.
- R6: On accepting a word, the port stores it. From the next cycle irq and data-held are high and dev_in_ready is low.
- R7: A read issued while busy (fetching or holding) or while disabled is ignored and sets the sticky error flag. A held word is kept unchanged.
- R8: A pulse on irq_ack drops irq in the next cycle. The held word and the data-held flag are not affected.
- R9: Data-take (code 4) while a word is held returns it in the next cycle with bus_rvalid high, and clears irq, busy and data-held. Data-take with nothing held sets error and gives no bus_rvalid.
- R10: Write (code 3) while enabled with no write pending raises dev_out_valid in the next cycle with bus_wdata. Valid and data stay stable until dev_out_ready. A write while one is pending or while disabled sets error and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Single-cycle command strobe |
| bus_addr | input | ADDR_W | Bus address compared with BASE_ADDR |
| bus_cmd | input | 3 | Command code |
| bus_wdata | input | DATA_W | Write data / control bits |
| bus_rvalid | output | 1 | Read data valid, one cycle |
| bus_rdata | output | DATA_W | Status or fetched word |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| dev_in_valid | input | 1 | Peripheral word valid |
| dev_in_ready | output | 1 | Port ready to take a peripheral word |
| dev_in_data | input | DATA_W | Peripheral word |
| dev_out_valid | output | 1 | Outbound word valid |
| dev_out_ready | input | 1 | Peripheral accepts outbound word |
| dev_out_data | output | DATA_W | Outbound word |

## Verification
The bench targets the following misuse cases:
- a second read while a word is still held;
- a take with nothing held;
- a write into a stalled outbound slot;
- commands sent to a foreign address.

A design that overwrote the held word, or restarted the fetch, would return the wrong word or drop busy. A design that treated a foreign-address strobe as its own would show busy. The bench also acknowledges the interrupt before taking the word. A design that tied data-held to irq would lose the word there. Random peripheral delays check that irq never rises before the handshake edge.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [2:0] {
    CMD_CTRL  = 3'd0,
    CMD_TEST  = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_TAKE  = 3'd4
  } iop_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2
  } iop_state_t;

  localparam int ST_BUSY_BIT  = 0;
  localparam int ST_HELD_BIT  = 1;
  localparam int ST_ERR_BIT   = 2;
  localparam int ST_EN_BIT    = 3;
  localparam int ST_WPEND_BIT = 4;
endpackage

// File: rtl/iop_decode.sv
module iop_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        cmd,
  output logic              do_ctrl,
  output logic              do_test,
  output logic              do_read,
  output logic              do_write,
  output logic              do_take
);
  import iop_pkg::*;
  logic hit;
  iop_cmd_t code;

  always_comb begin
    hit      = req && (addr == BASE_ADDR);
    code     = iop_cmd_t'(cmd);
    do_ctrl  = 1'b0;
    do_test  = 1'b0;
    do_read  = 1'b0;
    do_write = 1'b0;
    do_take  = 1'b0;
    if (hit) begin
      case (code)
        CMD_CTRL:  do_ctrl  = 1'b1;
        CMD_TEST:  do_test  = 1'b1;
        CMD_READ:  do_read  = 1'b1;
        CMD_WRITE: do_write = 1'b1;
        CMD_TAKE:  do_take  = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/iop_fetch.sv
module iop_fetch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic              ack,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              holding,
  output logic              irq,
  output logic [DATA_W-1:0] word
);
  import iop_pkg::*;
  iop_state_t state;
  logic       capture;

  assign in_ready = (state == ST_FETCH);
  assign capture  = in_ready && in_valid;
  assign busy     = (state != ST_IDLE);
  assign holding  = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      word  <= '0;
      irq   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_FETCH;
        ST_FETCH: if (capture) begin
          state <= ST_HOLD;
          word  <= in_data;
        end
        ST_HOLD:  if (take) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      if (capture)          irq <= 1'b1;
      else if (ack || take) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/iop_writer.sv
module iop_writer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_input_port.sv
module irq_input_port #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_cmd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              irq_ack,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data
);
  import iop_pkg::*;

  logic do_ctrl, do_test, do_read, do_write, do_take;
  logic busy, holding;
  logic enable_q, error_q;
  logic read_ok, take_ok, write_ok, any_bad;
  logic [DATA_W-1:0] word, status;

  iop_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .req(bus_req), .addr(bus_addr), .cmd(bus_cmd),
    .do_ctrl(do_ctrl), .do_test(do_test), .do_read(do_read),
    .do_write(do_write), .do_take(do_take)
  );

  assign read_ok  = do_read && enable_q && !busy;
  assign take_ok  = do_take && holding;
  assign write_ok = do_write && enable_q && !dev_out_valid;
  assign any_bad  = (do_read && !read_ok) || (do_take && !take_ok) ||
                    (do_write && !write_ok);

  iop_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(read_ok), .take(take_ok), .ack(irq_ack),
    .in_valid(dev_in_valid), .in_data(dev_in_data), .in_ready(dev_in_ready),
    .busy(busy), .holding(holding), .irq(irq), .word(word)
  );

  iop_writer #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(write_ok), .load_data(bus_wdata),
    .out_valid(dev_out_valid), .out_data(dev_out_data), .out_ready(dev_out_ready)
  );

  always_comb begin
    status               = '0;
    status[ST_BUSY_BIT]  = busy;
    status[ST_HELD_BIT]  = holding;
    status[ST_ERR_BIT]   = error_q;
    status[ST_EN_BIT]    = enable_q;
    status[ST_WPEND_BIT] = dev_out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= 1'b0;
      error_q    <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (do_ctrl) begin
        enable_q <= bus_wdata[0];
        if (bus_wdata[1]) error_q <= 1'b0;
      end else if (any_bad) begin
        error_q <= 1'b1;
      end
      bus_rvalid <= do_test || take_ok;
      if (do_test)      bus_rdata <= status;
      else if (take_ok) bus_rdata <= word;
    end
  end
endmodule

// File: rtl/irq_input_port_checker.sv
module irq_input_port_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              irq,
  input logic              irq_ack,
  input logic              dev_in_valid,
  input logic              dev_in_ready,
  input logic              dev_out_valid,
  input logic              dev_out_ready,
  input logic [DATA_W-1:0] dev_out_data
);
  p_rvalid_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && (bus_addr == BASE_ADDR)));

  p_irq_from_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(dev_in_valid && dev_in_ready));

  p_no_ready_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !dev_in_ready);

  p_ack_drops_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack) |=> !irq);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));
endmodule

bind irq_input_port irq_input_port_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .irq(irq), .irq_ack(irq_ack),
  .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
  .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
  .dev_out_data(dev_out_data)
);

// File: tb/irq_input_port_test.sv
module irq_input_port_test;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [2:0] bus_cmd = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [DW-1:0] bus_rdata;
  logic irq;
  logic irq_ack = 1'b0;
  logic dev_in_valid = 1'b0;
  logic dev_in_ready;
  logic [DW-1:0] dev_in_data = '0;
  logic dev_out_valid;
  logic dev_out_ready = 1'b0;
  logic [DW-1:0] dev_out_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  irq_input_port #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .irq(irq), .irq_ack(irq_ack),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] exp_status(bit b, bit h, bit e, bit en, bit wp);
    logic [DW-1:0] s = '0;
    s[0] = b; s[1] = h; s[2] = e; s[3] = en; s[4] = wp;
    return s;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic [DW-1:0] d, logic [AW-1:0] a);
    @(negedge clk);
    bus_req = 1'b1; bus_cmd = c; bus_wdata = d; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0; bus_wdata = '0;
  endtask

  task automatic test_status(string tag, logic [DW-1:0] exp);
    issue(3'd1, '0, BASE);
    chk({tag, " rvalid"}, {15'd0, bus_rvalid}, 16'd1);
    chk({tag, " status"}, bus_rdata, exp);
  endtask

  task automatic feed(logic [DW-1:0] w, int dly);
    for (int i = 0; i < dly; i++) @(negedge clk);
    dev_in_valid = 1'b1; dev_in_data = w;
    forever begin
      automatic logic got = dev_in_ready;
      @(negedge clk);
      if (got) break;
    end
    dev_in_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1234_5678);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 in_ready", {15'd0, dev_in_ready}, 16'd0);
    chk("R1 out_valid", {15'd0, dev_out_valid}, 16'd0);
    chk("R1 rvalid", {15'd0, bus_rvalid}, 16'd0);
    rst_n = 1'b1;
    test_status("R1 R4", exp_status(0, 0, 0, 0, 0));

    // R7 read while disabled
    issue(3'd2, '0, BASE);
    test_status("R7 disabled read", exp_status(0, 0, 1, 0, 0));
    // R3 enable and clear error
    issue(3'd0, 16'h0003, BASE);
    test_status("R3 enable clear", exp_status(0, 0, 0, 1, 0));

    // R2 foreign address and unused code
    issue(3'd2, '0, 8'h41);
    chk("R2 foreign rvalid", {15'd0, bus_rvalid}, 16'd0);
    chk("R2 foreign in_ready", {15'd0, dev_in_ready}, 16'd0);
    issue(3'd6, '0, BASE);
    chk("R2 code6 rvalid", {15'd0, bus_rvalid}, 16'd0);
    test_status("R2 untouched", exp_status(0, 0, 0, 1, 0));

    // R5 read starts fetch
    issue(3'd2, '0, BASE);
    chk("R5 in_ready", {15'd0, dev_in_ready}, 16'd1);
    chk("R5 no irq yet", {15'd0, irq}, 16'd0);
    test_status("R5 busy", exp_status(1, 0, 0, 1, 0));
    feed(16'hA5C3, 2);
    chk("R6 irq", {15'd0, irq}, 16'd1);
    chk("R6 in_ready low", {15'd0, dev_in_ready}, 16'd0);
    test_status("R6 held", exp_status(1, 1, 0, 1, 0));
    // R7 read while holding
    issue(3'd2, '0, BASE);
    test_status("R7 busy read", exp_status(1, 1, 1, 1, 0));
    // R8 ack drops irq, keeps word
    pulse_ack();
    chk("R8 irq low", {15'd0, irq}, 16'd0);
    test_status("R8 still held", exp_status(1, 1, 1, 1, 0));
    // R9 take
    issue(3'd4, '0, BASE);
    chk("R9 rvalid", {15'd0, bus_rvalid}, 16'd1);
    chk("R9 word", bus_rdata, 16'hA5C3);
    test_status("R9 idle", exp_status(0, 0, 1, 1, 0));
    issue(3'd0, 16'h0003, BASE);
    issue(3'd4, '0, BASE);
    chk("R9 empty take rvalid", {15'd0, bus_rvalid}, 16'd0);
    test_status("R9 empty take err", exp_status(0, 0, 1, 1, 0));
    issue(3'd0, 16'h0003, BASE);

    // R10 write with backpressure
    issue(3'd3, 16'hBEEF, BASE);
    chk("R10 out_valid", {15'd0, dev_out_valid}, 16'd1);
    chk("R10 out_data", dev_out_data, 16'hBEEF);
    issue(3'd3, 16'h1111, BASE);
    chk("R10 stalled data", dev_out_data, 16'hBEEF);
    test_status("R10 pending err", exp_status(0, 0, 1, 1, 1));
    @(negedge clk); dev_out_ready = 1'b1;
    @(negedge clk); dev_out_ready = 1'b0;
    chk("R10 drained", {15'd0, dev_out_valid}, 16'd0);
    issue(3'd0, 16'h0003, BASE);

    // random fetch/take rounds
    for (int n = 0; n < 30; n++) begin
      automatic logic [DW-1:0] w = DW'($urandom);
      automatic int d = $urandom_range(0, 4);
      automatic bit do_ack = $urandom_range(0, 1) == 1;
      issue(3'd2, '0, BASE);
      feed(w, d);
      chk("R6 rand irq", {15'd0, irq}, 16'd1);
      if (do_ack) begin
        pulse_ack();
        chk("R8 rand ack", {15'd0, irq}, 16'd0);
      end
      issue(3'd4, '0, BASE);
      chk("R9 rand word", bus_rdata, w);
      chk("R9 rand irq clear", {15'd0, irq}, 16'd0);
      test_status("R9 rand idle", exp_status(0, 0, 0, 1, 0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule